// File: doc/BRIEF.md
# Hourly Chime and Alarm Buzzer

This block drives one buzzer bit for a digital clock. It watches the current time and the stored alarm time, both as BCD digits, and plays two sound patterns. Just before each hour it gives a short chime of four low pips followed by one high pip. When the time reaches the alarm setting it beeps once per second for a fixed number of seconds. One enable input silences everything.

The tone base is the block's own clock. A free-running two-bit divider gives the high tone at half the clock rate and the low tone at a quarter of it. Run from a 2048 Hz clock, this yields the 1024 Hz and 512 Hz pitches. A one-cycle `sec_tick` pulse marks the start of every second, and the time digits change on that same edge. The block uses the tick to split each second into a sounding half and a silent half. It also uses the tick to count down the alarm's duration.

Top module: `hourly_buzzer`

## Requirements
- R1: While reset is asserted and after reset with no event pending, `buzz` is low.
- R2: When the minute digits read 59 and the second digits read 51, 53, 55 or 57, `buzz` carries the low tone for that whole second. The low tone is a square wave with a period of four clocks.
- R3: When the minute and second digits both read 59, `buzz` carries the high tone for that whole second. The high tone toggles on every clock.
- R4: Outside the events of R2, R3 and R5, `buzz` stays low. This covers even seconds of minute 59, minute-59 seconds below 50, and odd seconds of any other minute.
- R5: The alarm starts when all six digits of `now_bcd` first become equal to `alarm_bcd`. Fields run from bit 23 down as hour tens, hour units, minute tens, minute units, second tens, second units, four bits each. While the alarm is active, each second carries the low tone during its first CYC_PER_SEC/2 clocks after the tick and is silent for the rest.
- R6: The alarm stays active for exactly ALARM_SECS ticked seconds, counting the matching second. The second after that is silent.
- R7: When the alarm and the chime overlap, the alarm pattern is played and the chime is not.
- R8: While `enable` is low, `buzz` is low. Dropping `enable` cancels a running alarm, so it stays silent after `enable` returns.
- R9: A match that begins while `enable` is low does not start the alarm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tone-base clock; one buzzer sample per edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Sound enable; low silences output and cancels the alarm |
| sec_tick | input | 1 | One-clock pulse at the start of each second |
| now_bcd | input | 24 | Current time, six BCD digits hh:mm:ss |
| alarm_bcd | input | 24 | Alarm time, six BCD digits hh:mm:ss |
| buzz | output | 1 | Buzzer drive |

## Verification
The bench builds the block with CYC_PER_SEC set to 16 and keeps ALARM_SECS at its default of 10. Each simulated second is therefore short enough to sample clock by clock. Counting high samples and toggles in each half-second then tells silence, the low tone, the high tone and the half-second beep apart. With ten-second alarms at this rate, the whole alarm lifetime, its overlap with the chime and its cancellation by `enable` all fit in a few hundred cycles.

// File: rtl/buzzer_pkg.sv
package buzzer_pkg;
    localparam int DIGIT_W = 4;
    localparam int TIME_W  = 6 * DIGIT_W;
    localparam int MS_W    = 4 * DIGIT_W;

    typedef enum logic [1:0] {
        SEL_OFF  = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_BEEP = 2'd3
    } tone_sel_e;
endpackage

// File: rtl/chime_decode.sv
module chime_decode
    import buzzer_pkg::*;
(
    input  logic [MS_W-1:0] ms_bcd,
    output logic            pip_lo,
    output logic            pip_hi
);
    logic [DIGIT_W-1:0] min_t, min_u, sec_t, sec_u;
    logic               last_min, sec_fifties;

    always_comb begin
        min_t       = ms_bcd[4*DIGIT_W-1:3*DIGIT_W];
        min_u       = ms_bcd[3*DIGIT_W-1:2*DIGIT_W];
        sec_t       = ms_bcd[2*DIGIT_W-1:DIGIT_W];
        sec_u       = ms_bcd[DIGIT_W-1:0];
        last_min    = (min_t == DIGIT_W'(5)) && (min_u == DIGIT_W'(9));
        sec_fifties = last_min && (sec_t == DIGIT_W'(5));
        pip_hi      = sec_fifties && (sec_u == DIGIT_W'(9));
        pip_lo      = sec_fifties && sec_u[0] && (sec_u < DIGIT_W'(9));
    end
endmodule

// File: rtl/alarm_timer.sv
module alarm_timer #(
    parameter int CYC_PER_SEC = 2048,
    parameter int ALARM_SECS  = 10,
    localparam int CNT_W      = $clog2(ALARM_SECS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sec_tick,
    input  logic             match,
    output logic             active_next,
    output logic             beep_next,
    output logic [CNT_W-1:0] remain
);
    localparam int SUB_W = $clog2(CYC_PER_SEC);
    localparam int HALF  = CYC_PER_SEC / 2;

    typedef struct packed {
        logic             seen;
        logic [CNT_W-1:0] rem;
        logic [SUB_W-1:0] sub;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.seen = match;
        if (sec_tick) begin
            st_d.sub = '0;
        end else if (st_q.sub != SUB_W'(CYC_PER_SEC - 1)) begin
            st_d.sub = st_q.sub + 1'b1;
        end
        if (!enable) begin
            st_d.rem = '0;
        end else if (match && !st_q.seen) begin
            st_d.rem = CNT_W'(ALARM_SECS);
        end else if (sec_tick && (st_q.rem != '0)) begin
            st_d.rem = st_q.rem - 1'b1;
        end
        active_next = (st_d.rem != '0);
        beep_next   = (st_d.sub < SUB_W'(HALF));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign remain = st_q.rem;
endmodule

// File: rtl/hourly_buzzer.sv
module hourly_buzzer
    import buzzer_pkg::*;
#(
    parameter int CYC_PER_SEC = 2048,
    parameter int ALARM_SECS  = 10,
    localparam int CNT_W      = $clog2(ALARM_SECS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sec_tick,
    input  logic [TIME_W-1:0] now_bcd,
    input  logic [TIME_W-1:0] alarm_bcd,
    output logic              buzz
);
    typedef struct packed {
        logic [1:0] tone;
        logic       buzz;
    } out_t;

    out_t             ou_d, ou_q;
    logic             pip_lo, pip_hi, chime_any;
    logic             alarm_next, beep_next, match;
    logic [CNT_W-1:0] alarm_rem;
    tone_sel_e        sel;

    assign match     = (now_bcd == alarm_bcd);
    assign chime_any = pip_lo || pip_hi;

    chime_decode u_chime (
        .ms_bcd (now_bcd[MS_W-1:0]),
        .pip_lo (pip_lo),
        .pip_hi (pip_hi)
    );

    alarm_timer #(
        .CYC_PER_SEC (CYC_PER_SEC),
        .ALARM_SECS  (ALARM_SECS)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .sec_tick    (sec_tick),
        .match       (match),
        .active_next (alarm_next),
        .beep_next   (beep_next),
        .remain      (alarm_rem)
    );

    always_comb begin
        ou_d.tone = ou_q.tone + 2'd1;
        if (!enable) begin
            sel = SEL_OFF;
        end else if (alarm_next) begin
            sel = SEL_BEEP;
        end else if (pip_hi) begin
            sel = SEL_HI;
        end else if (pip_lo) begin
            sel = SEL_LO;
        end else begin
            sel = SEL_OFF;
        end
        unique case (sel)
            SEL_LO:   ou_d.buzz = ou_d.tone[1];
            SEL_HI:   ou_d.buzz = ou_d.tone[0];
            SEL_BEEP: ou_d.buzz = beep_next && ou_d.tone[1];
            default:  ou_d.buzz = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ou_q <= '0;
        end else begin
            ou_q <= ou_d;
        end
    end

    assign buzz = ou_q.buzz;
endmodule

// File: rtl/buzzer_checker.sv
module buzzer_checker #(
    parameter int ALARM_SECS  = 10,
    localparam int CNT_W      = $clog2(ALARM_SECS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             buzz,
    input logic             chime_any,
    input logic             alarm_next,
    input logic             beep_next,
    input logic [CNT_W-1:0] alarm_rem
);
    p_off_when_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !buzz);

    p_cancel_on_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (alarm_rem == '0));

    p_count_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_rem != '0 |-> alarm_rem <= CNT_W'(ALARM_SECS));

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_rem != '0 && alarm_rem != $past(alarm_rem))
            |-> (alarm_rem == $past(alarm_rem) - 1'b1 || alarm_rem == CNT_W'(ALARM_SECS)));

    p_start_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_rem != '0) |-> $past(enable));

    p_silent_without_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!chime_any && !alarm_next) |=> !buzz);

    p_alarm_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_next && !beep_next) |=> !buzz);
endmodule

bind hourly_buzzer buzzer_checker #(
    .ALARM_SECS (ALARM_SECS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .buzz       (buzz),
    .chime_any  (chime_any),
    .alarm_next (alarm_next),
    .beep_next  (beep_next),
    .alarm_rem  (alarm_rem)
);

// File: tb/tb_hourly_buzzer.sv
module tb_hourly_buzzer;
    localparam int CYC  = 16;
    localparam int HALF = CYC / 2;
    localparam int NVEC = 12;
    localparam logic [1:0] E_OFF = 2'd0, E_LO = 2'd1, E_HI = 2'd2, E_BEEP = 2'd3;

    // {time hh:mm:ss in BCD, expected pattern}
    localparam logic [25:0] VEC [NVEC] = '{
        {24'h105951, E_LO},  {24'h105952, E_OFF}, {24'h105953, E_LO},
        {24'h105955, E_LO},  {24'h105957, E_LO},  {24'h105959, E_HI},
        {24'h105851, E_OFF}, {24'h105950, E_OFF}, {24'h105949, E_OFF},
        {24'h105958, E_OFF}, {24'h235959, E_HI},  {24'h110000, E_OFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        sec_tick = 1'b0;
    logic [23:0] now_bcd = 24'h000000;
    logic [23:0] alarm_bcd = 24'h123456;
    logic        buzz;
    int          n_cmp = 0;
    int          n_bad = 0;
    logic        done = 1'b0;

    hourly_buzzer #(.CYC_PER_SEC(CYC), .ALARM_SECS(10)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .sec_tick  (sec_tick),
        .now_bcd   (now_bcd),
        .alarm_bcd (alarm_bcd),
        .buzz      (buzz)
    );

    always #4 clk = ~clk;

    task automatic run_second(input logic [23:0] t, input logic en,
                              input logic [1:0] exp, input string tag);
        int   hf = 0, hs = 0, tf = 0;
        logic prev = 1'b0;
        logic ok;
        now_bcd  = t;
        enable   = en;
        sec_tick = 1'b1;
        for (int i = 0; i < CYC; i++) begin
            @(negedge clk);
            if (i == 0) sec_tick = 1'b0;
            if (i < HALF) begin
                hf += int'(buzz);
                if (i > 0 && buzz != prev) tf++;
            end else begin
                hs += int'(buzz);
            end
            prev = buzz;
        end
        case (exp)
            E_OFF:   ok = (hf == 0) && (hs == 0);
            E_LO:    ok = (hf == HALF/2) && (hs == HALF/2) && (tf >= HALF/2 - 1) && (tf <= HALF/2);
            E_HI:    ok = (hf == HALF/2) && (hs == HALF/2) && (tf == HALF - 1);
            default: ok = (hf == HALF/2) && (hs == 0) && (tf >= HALF/2 - 1) && (tf <= HALF/2);
        endcase
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s time %h: actual highs %0d/%0d toggles %0d, expected pattern %0d",
                     tag, t, hf, hs, tf, exp);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        int highs;
        highs = 0;
        repeat (3) @(negedge clk);
        highs += int'(buzz);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            highs += int'(buzz);
        end
        n_cmp++;
        if (highs != 0) begin
            n_bad++;
            $display("FAIL R1 reset/idle: actual %0d high samples, expected 0", highs);
        end

        // table of chime seconds: R2, R3, R4
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][1:0])
                E_LO:    run_second(VEC[i][25:2], 1'b1, VEC[i][1:0], "R2 low pip");
                E_HI:    run_second(VEC[i][25:2], 1'b1, VEC[i][1:0], "R3 high pip");
                default: run_second(VEC[i][25:2], 1'b1, VEC[i][1:0], "R4 silent");
            endcase
        end

        // R5, R6: alarm at 12:34:56 for ten seconds
        run_second(24'h123455, 1'b1, E_OFF, "R5 before match");
        run_second(24'h123456, 1'b1, E_BEEP, "R5 match second");
        for (int s = 57; s <= 59; s++)
            run_second({16'h1234, 4'(s / 10), 4'(s % 10)}, 1'b1, E_BEEP, "R6 alarm running");
        for (int s = 0; s <= 5; s++)
            run_second({16'h1235, 4'(s / 10), 4'(s % 10)}, 1'b1, E_BEEP, "R6 alarm running");
        run_second(24'h123506, 1'b1, E_OFF, "R6 eleventh second");

        // R7: alarm overlapping the chime
        alarm_bcd = 24'h075950;
        run_second(24'h075949, 1'b1, E_OFF, "R7 before");
        for (int s = 50; s <= 59; s++)
            run_second({16'h0759, 4'(s / 10), 4'(s % 10)}, 1'b1, E_BEEP, "R7 alarm over chime");
        run_second(24'h080000, 1'b1, E_OFF, "R7 after");

        // R8: disable silences and cancels
        alarm_bcd = 24'h030000;
        run_second(24'h030000, 1'b1, E_BEEP, "R8 alarm start");
        run_second(24'h030001, 1'b0, E_OFF, "R8 disabled");
        run_second(24'h030002, 1'b1, E_OFF, "R8 cancelled");
        run_second(24'h030003, 1'b1, E_OFF, "R8 cancelled");
        run_second(24'h105951, 1'b0, E_OFF, "R8 chime disabled");
        run_second(24'h105953, 1'b1, E_LO, "R8 chime re-enabled");

        // R9: match beginning while disabled
        alarm_bcd = 24'h040000;
        run_second(24'h040000, 1'b0, E_OFF, "R9 match while disabled");
        run_second(24'h040001, 1'b1, E_OFF, "R9 no late start");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end
endmodule